// File: doc/BRIEF.md
# Interpolating DAC Data-Clock Phase Aligner

This block runs on the fast converter clock and derives from it a slower data clock. The data clock's period equals the selected interpolation factor of 2, 4 or 8 converter cycles, and its duty cycle is 50%. It also raises a one-cycle latch strobe that marks the converter-clock cycle in which the parallel input word is captured. The captured word is held on an output register until the next strobe.

A 4-bit two's-complement adjust code slides the data clock, and the latch strobe with it, by whole converter-clock cycles. The code is reduced modulo the data-clock period. Coarser factors ignore low code bits, so the set of distinct codes shrinks with the factor. A polarity input chooses where the strobe sits:
- in the last low cycle before a data-clock rising edge, or
- in the first high cycle after that edge.

The block drives the data clock itself. The adjust code and the factor are taken only at the end of a data-clock period, so a retune never produces a runt high pulse.

Cycle index k used below: k = 0 is the converter-clock cycle in which reset is first low, and k increases by one at every rising edge after that. An internal reference count starts at zero in cycle 0 and free-runs modulo 8.

Top module: `dclk_phase_aligner`

## Requirements
- R1: While reset is high, dataClk, latchStb and dataOut are all 0. After reset the applied offset is 0 and the applied factor is the one on modeSel during reset; both stay in force until the first period end, even if adjCode is non-zero.
- R2: modeSel selects the factor F: 2'b00 gives 2, 2'b01 gives 4, and 2'b10 or 2'b11 gives 8. With settings held steady and offset `off`, dataClk in cycle k is 1 exactly when ((k-1-off) mod F) < F/2.
- R3: In 8x, off = adjCode mod 8, with the code read as two's complement. 4'b1111 moves the data clock one cycle earlier than 4'b0000, 4'b0001 moves it one cycle later, and 4'b1000 aligns like 4'b0000.
- R4: In 4x, adjCode bit 0 is ignored and off = 2·adjCode[1]. In 2x, bits 1 and 0 are ignored, so every code gives off = 0.
- R5: With latchPol = 0, latchStb is high for one cycle, in the cycle k ≡ off (mod F). That is the last low cycle before a data-clock rising edge.
- R6: With latchPol = 1, latchStb is high in the cycle k ≡ off+1 (mod F). That is the first high cycle of the data clock.
- R7: In the cycle after a strobe, dataOut holds the dataIn value present during the strobe cycle. At any other time it keeps its value.
- R8: New adjCode or modeSel values take effect only at the end of a data-clock period. A change made mid-period leaves dataClk on its old pattern up to and including the last low cycle of the current period.
- R9: dataClk is never high for more than four consecutive cycles, even across changes of factor or offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| modeSel | input | 2 | Interpolation factor select |
| adjCode | input | 4 | Two's-complement cycle offset of the data clock |
| latchPol | input | 1 | Strobe placement: 0 before the rising edge, 1 after it |
| dataIn | input | 16 | Parallel input word |
| dataClk | output | 1 | Generated data clock |
| latchStb | output | 1 | One-cycle capture strobe |
| dataOut | output | 16 | Captured word |

## Verification
The period-end cycle is where two functions meet. In that cycle the block takes a new offset or factor, and in the same cycle it decides whether the next cycle carries a polarity-0 strobe, using the phase that the new settings produce. The bench changes the adjust code in the middle of a period and checks that dataClk keeps its old pattern through the switch cycle. It then checks that strobes and captured words follow the new offset, and that no strobe appears at the old position. Changes of factor and offset also run with a tally of consecutive high cycles, which catches a stretched or duplicated pulse at the switch.

// File: rtl/dclk_align_pkg.sv
package dclk_align_pkg;

  // Next-cycle values the phase control hands to the capture path
  typedef struct packed {
    logic clkNext;    // data clock level for the coming cycle
    logic latchNext;  // capture strobe for the coming cycle
  } alignStrobe_t;

endpackage

// File: rtl/dclk_phase_ctrl.sv
module dclk_phase_ctrl
  import dclk_align_pkg::*;
#(
  parameter int MODE_W = 2,
  parameter int ADJ_W  = 4,
  parameter int PH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] modeIn,
  input  logic [ADJ_W-1:0]  adjIn,
  input  logic              polIn,
  input  logic              dataClk,
  output alignStrobe_t      strb
);

  // Phase mask (F-1) for a mode: bit i set when i <= mode, capped at PH_W bits
  function automatic logic [PH_W-1:0] maskOf(input logic [MODE_W-1:0] m);
    logic [PH_W-1:0] r;
    for (int i = 0; i < PH_W; i++) r[i] = (i <= int'(m));
    return r;
  endfunction

  // Code bits that survive: below the period width, above the ignored low bits
  function automatic logic [ADJ_W-1:0] keepOf(input logic [MODE_W-1:0] m);
    logic [ADJ_W-1:0] r;
    for (int i = 0; i < ADJ_W; i++)
      r[i] = (i < PH_W) && (i <= int'(m)) && (i >= PH_W - 1 - int'(m));
    return r;
  endfunction

  function automatic logic [PH_W-1:0] halfOf(input logic [MODE_W-1:0] m);
    logic [PH_W-1:0] k;
    k = maskOf(m);
    return (k >> 1) + 1'b1;
  endfunction

  logic [PH_W-1:0]   refCnt, curOff, nextOff;
  logic [PH_W-1:0]   ph, phNext, curMask, nextMask;
  logic [MODE_W-1:0] curMode, nextMode;
  logic              wrap, inHigh, nextHigh;

  always_comb begin
    curMask  = maskOf(curMode);
    ph       = (refCnt - curOff) & curMask;
    wrap     = (ph == curMask);
    nextMode = wrap ? modeIn : curMode;
    nextOff  = wrap ? PH_W'(adjIn & keepOf(modeIn)) : curOff;
    nextMask = maskOf(nextMode);
    phNext   = (refCnt + 1'b1 - nextOff) & nextMask;
    inHigh   = (ph < halfOf(curMode));
    nextHigh = (phNext < halfOf(nextMode));
    strb.clkNext   = inHigh;
    strb.latchNext = polIn ? (inHigh && !dataClk) : (nextHigh && !inHigh);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      refCnt  <= '0;
      curOff  <= '0;
      curMode <= modeIn;
    end else begin
      refCnt <= refCnt + 1'b1;
      if (wrap) begin
        curOff  <= nextOff;
        curMode <= nextMode;
      end
    end
  end

  // R8: the last low cycle of a period is followed by a cycle that is either
  // low again (later shift) or the start of a high phase; never a stuck-high run
  wrap_low_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !dataClk);

endmodule

// File: rtl/dclk_capture_path.sv
module dclk_capture_path
  import dclk_align_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  alignStrobe_t      strb,
  input  logic [DATA_W-1:0] dataIn,
  output logic              dataClk,
  output logic              latchStb,
  output logic [DATA_W-1:0] dataOut
);

  localparam int HALF_MAX = 1 << (PH_W - 1);
  localparam int RUN_W    = $clog2(HALF_MAX + 2);

  logic [RUN_W-1:0] hiRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataClk  <= 1'b0;
      latchStb <= 1'b0;
      dataOut  <= '0;
      hiRun    <= '0;
    end else begin
      dataClk  <= strb.clkNext;
      latchStb <= strb.latchNext;
      if (latchStb) dataOut <= dataIn;
      if (!strb.clkNext)                       hiRun <= '0;
      else if (hiRun != RUN_W'(HALF_MAX + 1))  hiRun <= hiRun + 1'b1;
    end
  end

  // R9
  hi_run_chk: assert property (@(posedge clk) disable iff (rst)
    hiRun <= RUN_W'(HALF_MAX));

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dataOut) |-> $past(latchStb));

endmodule

// File: rtl/dclk_phase_aligner.sv
module dclk_phase_aligner
  import dclk_align_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MODE_W = 2,
  parameter int ADJ_W  = 4,
  parameter int PH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] modeSel,
  input  logic [ADJ_W-1:0]  adjCode,
  input  logic              latchPol,
  input  logic [DATA_W-1:0] dataIn,
  output logic              dataClk,
  output logic              latchStb,
  output logic [DATA_W-1:0] dataOut
);

  alignStrobe_t strb;

  dclk_phase_ctrl #(
    .MODE_W(MODE_W), .ADJ_W(ADJ_W), .PH_W(PH_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .modeIn(modeSel), .adjIn(adjCode),
    .polIn(latchPol), .dataClk(dataClk), .strb(strb)
  );

  dclk_capture_path #(
    .DATA_W(DATA_W), .PH_W(PH_W)
  ) i_path (
    .clk(clk), .rst(rst), .strb(strb), .dataIn(dataIn),
    .dataClk(dataClk), .latchStb(latchStb), .dataOut(dataOut)
  );

  // R5
  pol_low_chk: assert property (@(posedge clk) disable iff (rst)
    latchStb && !$past(latchPol) |=> $rose(dataClk));

  // R6
  pol_high_chk: assert property (@(posedge clk) disable iff (rst)
    latchStb && $past(latchPol) |-> $rose(dataClk));

endmodule

// File: tb/test_dclk_phase_aligner.sv
module test_dclk_phase_aligner;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    modeSel = 2'b10;
  logic [3:0]    adjCode = 4'b0000;
  logic          latchPol = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic          dataClk, latchStb;
  logic [DW-1:0] dataOut;

  int  nRun = 0, nFail = 0, cyc = 0, hiRun = 0;
  bit  done = 1'b0;
  logic [DW-1:0] held = '0;

  dclk_phase_aligner i_dclk_phase_aligner (
    .clk(clk), .rst(rst), .modeSel(modeSel), .adjCode(adjCode),
    .latchPol(latchPol), .dataIn(dataIn), .dataClk(dataClk),
    .latchStb(latchStb), .dataOut(dataOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  function automatic int facOf(input logic [1:0] m);
    return (m == 2'b00) ? 2 : (m == 2'b01) ? 4 : 8;
  endfunction

  function automatic int offOf(input logic [3:0] a, input logic [1:0] m);
    if (m == 2'b00) return 0;
    if (m == 2'b01) return a[1] ? 2 : 0;
    return int'(a[2:0]);
  endfunction

  function automatic int modF(input int v, input int f);
    return ((v % f) + f) % f;
  endfunction

  function automatic logic [DW-1:0] patOf(input int k);
    return DW'((k * 40503) ^ 16'h5A3C);
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  // One cycle: sample at the falling edge, check the held word, drive new data
  task automatic step();
    @(negedge clk);
    check(dataOut == held, "R7 captured word", int'(dataOut), int'(held));
    hiRun = dataClk ? hiRun + 1 : 0;
    if (latchStb) held = patOf(cyc);
    dataIn = patOf(cyc);
  endtask

  task automatic steadyRun(input logic [1:0] m, input logic [3:0] a, input bit p,
                           input string tag);
    int f, o;
    modeSel = m; adjCode = a; latchPol = p;
    repeat (20) step();
    f = facOf(m); o = offOf(a, m);
    for (int i = 0; i < 24; i++) begin
      bit eClk, eStb;
      step();
      eClk = modF(cyc - 1 - o, f) < f / 2;
      eStb = p ? (modF(cyc, f) == modF(o + 1, f)) : (modF(cyc, f) == o);
      check(dataClk == eClk, {tag, " dataClk"}, int'(dataClk), int'(eClk));
      check(latchStb == eStb, {tag, " latchStb"}, int'(latchStb), int'(eStb));
    end
  endtask

  task automatic resetCheck();
    rst = 1'b1; modeSel = 2'b10; adjCode = 4'b0101; latchPol = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(dataClk == 1'b0, "R1 reset dataClk", int'(dataClk), 0);
      check(latchStb == 1'b0, "R1 reset latchStb", int'(latchStb), 0);
      check(dataOut == '0, "R1 reset dataOut", int'(dataOut), 0);
    end
    rst = 1'b0;
    held = '0;
    // First period keeps offset 0 although the code is 0101 (R1, R8)
    for (int i = 0; i < 8; i++) begin
      bit eClk;
      step();
      eClk = modF(cyc - 1, 8) < 4;
      check(dataClk == eClk, "R1 first period offset zero", int'(dataClk), int'(eClk));
    end
  endtask

  task automatic midChange();
    steadyRun(2'b10, 4'b0000, 1'b0, "R8 pre");
    while (modF(cyc, 8) != 1) step();
    adjCode = 4'b0011;   // new code arrives mid-period
    for (int i = 0; i < 7; i++) begin
      bit eClk;
      step();
      eClk = modF(cyc - 1, 8) < 4;
      check(dataClk == eClk, "R8 old pattern kept", int'(dataClk), int'(eClk));
    end
    steadyRun(2'b10, 4'b0011, 1'b0, "R8 post");
  endtask

  task automatic transitionRun(input logic [1:0] m, input logic [3:0] a);
    modeSel = m; adjCode = a;
    for (int i = 0; i < 24; i++) begin
      step();
      check(hiRun <= 4, "R9 high run", hiRun, 4);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual 20000 cycles expected completion earlier");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    resetCheck();
    steadyRun(2'b10, 4'b0000, 1'b0, "R2 R5 8x code 0");
    steadyRun(2'b10, 4'b1111, 1'b0, "R3 8x code 1111");
    steadyRun(2'b10, 4'b0001, 1'b0, "R3 8x code 0001");
    steadyRun(2'b10, 4'b1000, 1'b0, "R3 8x code 1000");
    steadyRun(2'b11, 4'b0110, 1'b0, "R2 mode 11");
    steadyRun(2'b01, 4'b0011, 1'b0, "R4 4x code 0011");
    steadyRun(2'b01, 4'b0110, 1'b1, "R6 4x pol1");
    steadyRun(2'b10, 4'b0101, 1'b1, "R6 8x pol1");
    steadyRun(2'b00, 4'b1011, 1'b0, "R4 2x code 1011");
    steadyRun(2'b00, 4'b0001, 1'b1, "R4 R6 2x pol1");
    midChange();
    transitionRun(2'b00, 4'b0000);
    transitionRun(2'b10, 4'b0111);
    transitionRun(2'b10, 4'b0100);
    transitionRun(2'b01, 4'b0010);
    transitionRun(2'b10, 4'b0011);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule